// File: doc/BRIEF.md
# Two-Plane Pixel Mixer with Global Alpha and Color Key

This block merges two pixel streams that arrive in lock step with the display scan: a background plane that covers the whole screen, and a foreground plane that covers only a rectangle. Software places the rectangle by its top-left corner. Its width is given in blocks of 16 pixels and its height in lines. Each pixel is RGB666: 18 bits with three 6-bit channels.

Inside the rectangle, one of two mixing modes applies. In the blend mode, a single 8-bit opacity value weights every foreground pixel of the window against the background. In the key mode, foreground pixels that match a programmed key color become holes, and the background shows through them. The two modes exclude each other. When the key mode is on, the opacity value is not used.

The scan logic presents the screen coordinate and both pixels on every cycle in which the pixel-clock enable is high. The mixed pixel, together with a delayed copy of the data-enable strobe, appears on the output registers one enabled cycle later.

Top module: `plane_mixer`

## Requirements
- R1: While `rst_n` is low, `out_pix` and `out_de` are 0. The pixel packing is red in bits [17:12], green in bits [11:6] and blue in bits [5:0]. After each rising clock edge with `pix_en` high, `out_pix` holds the result for the inputs presented in that cycle.
- R2: On a clock edge with `pix_en` low, `out_pix` and `out_de` keep their values.
- R3: On each enabled edge, `out_de` takes the value `de_in` had in that cycle.
- R4: A pixel is inside the window when both of these hold:
  - `win_x <= pos_x < win_x + 16*win_w16`
  - `win_y <= pos_y < win_y + win_h`

  Outside the window, the output equals `bg_pix`.
- R5: With `win_en` low, the output equals `bg_pix` at every position.
- R6: In blend mode (`key_en` low, inside an enabled window), each channel is `(fg*A + bg*(255-A) + 127) / 255`, rounded down. Here `A` is `alpha`, and the same `A` applies to every pixel of the window.
- R7: In blend mode, `alpha` = 0 gives exactly `bg_pix` and `alpha` = 255 gives exactly `fg_pix`.
- R8: In key mode (`key_en` high, inside an enabled window), the output is handled as follows:
  - A foreground pixel equal to `{key_r, key_g, key_b}` gives `bg_pix`.
  - Any other foreground pixel gives `fg_pix` unchanged, whatever `alpha` is.
- R9: With `key_en` low, the key color has no effect. A foreground pixel equal to the key color is blended like any other pixel.
- R10: A window with `win_w16` = 0 or `win_h` = 0 covers no pixel, so the output is `bg_pix` everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per enabled cycle |
| de_in | input | 1 | Data-enable strobe that travels with the pixel |
| pos_x | input | 10 | Current screen column |
| pos_y | input | 10 | Current screen line |
| bg_pix | input | 18 | Background pixel, RGB666 |
| fg_pix | input | 18 | Foreground pixel, RGB666 |
| win_en | input | 1 | Foreground window enable |
| alpha | input | 8 | Global opacity, 0 = invisible, 255 = opaque |
| key_en | input | 1 | Selects key mode instead of blend mode |
| key_r | input | 6 | Key color, red channel |
| key_g | input | 6 | Key color, green channel |
| key_b | input | 6 | Key color, blue channel |
| win_x | input | 10 | Window left column |
| win_y | input | 10 | Window top line |
| win_w16 | input | 6 | Window width in blocks of 16 pixels |
| win_h | input | 10 | Window height in lines |
| out_pix | output | 18 | Mixed pixel, RGB666 |
| out_de | output | 1 | Delayed data-enable |

## Verification
The bench builds the block with its default parameters: 6-bit channels, 8-bit alpha, 10-bit coordinates and a 6-bit width field. An 8-bit alpha selects the shift-and-add divider variant, so every opacity level, including the exact end points 0 and 255, is compared against integer division. The 10-bit coordinates combined with a width of up to 63 blocks let a window reach the right edge of the coordinate space, which exercises the widened end-column comparison. Directed cycles probe the columns and lines just outside and just inside each window edge, and the zero-width and zero-height cases.

// File: rtl/plane_mixer_pkg.sv
package plane_mixer_pkg;
   localparam int NUM_CH = 3;
   typedef enum logic [1:0] {
      SRC_BACK  = 2'd0,
      SRC_FRONT = 2'd1,
      SRC_MIX   = 2'd2
   } src_sel_e;
endpackage

// File: rtl/pm_win_hit.sv
module pm_win_hit #(
   parameter int X_W      = 10,
   parameter int Y_W      = 10,
   parameter int WW_W     = 6,
   parameter int UNIT_LG2 = 4
) (
   input  logic [X_W-1:0]  pos_x,
   input  logic [Y_W-1:0]  pos_y,
   input  logic [X_W-1:0]  org_x,
   input  logic [Y_W-1:0]  org_y,
   input  logic [WW_W-1:0] size_w,
   input  logic [Y_W-1:0]  size_h,
   output logic            hit
);
   localparam int XE_W = X_W + WW_W + UNIT_LG2 + 1;
   localparam int YE_W = Y_W + 1;

   logic [XE_W-1:0] x_lo, x_hi, x_cur;
   logic [YE_W-1:0] y_lo, y_hi, y_cur;

   assign x_lo  = XE_W'(org_x);
   assign x_hi  = x_lo + (XE_W'(size_w) << UNIT_LG2);
   assign x_cur = XE_W'(pos_x);
   assign y_lo  = YE_W'(org_y);
   assign y_hi  = y_lo + YE_W'(size_h);
   assign y_cur = YE_W'(pos_y);

   assign hit = (x_cur >= x_lo) && (x_cur < x_hi) &&
                (y_cur >= y_lo) && (y_cur < y_hi);
endmodule

// File: rtl/pm_chan_blend.sv
module pm_chan_blend #(
   parameter int CH_W    = 6,
   parameter int ALPHA_W = 8
) (
   input  logic [CH_W-1:0]    fg_ch,
   input  logic [CH_W-1:0]    bg_ch,
   input  logic [ALPHA_W-1:0] alpha,
   output logic [CH_W-1:0]    mix_ch
);
   localparam int FULL   = (1 << ALPHA_W) - 1;
   localparam int HALF   = FULL / 2;
   localparam int PROD_W = CH_W + ALPHA_W + 1;

   logic [ALPHA_W-1:0] inv_a;
   logic [PROD_W-1:0]  acc;

   // full-scale minus alpha is the bitwise complement
   assign inv_a = ~alpha;
   assign acc   = PROD_W'(fg_ch) * PROD_W'(alpha) +
                  PROD_W'(bg_ch) * PROD_W'(inv_a) + PROD_W'(HALF);

   generate
      if (ALPHA_W > CH_W) begin : g_shift_div
         // exact divide by 2^A-1 for operands below 2^(2A-1)
         logic [PROD_W:0] adj;
         assign adj    = {1'b0, acc} + (PROD_W+1)'(1) + (PROD_W+1)'(acc >> ALPHA_W);
         assign mix_ch = CH_W'(adj >> ALPHA_W);
      end else begin : g_true_div
         assign mix_ch = CH_W'(acc / PROD_W'(FULL));
      end
   endgenerate
endmodule

// File: rtl/pm_key_cmp.sv
module pm_key_cmp #(
   parameter int CH_W = 6
) (
   input  logic [3*CH_W-1:0] fg_pix,
   input  logic [CH_W-1:0]   key_r,
   input  logic [CH_W-1:0]   key_g,
   input  logic [CH_W-1:0]   key_b,
   output logic              match
);
   assign match = (fg_pix[3*CH_W-1:2*CH_W] == key_r) &&
                  (fg_pix[2*CH_W-1:CH_W]   == key_g) &&
                  (fg_pix[CH_W-1:0]        == key_b);
endmodule

// File: rtl/plane_mixer.sv
module plane_mixer
   import plane_mixer_pkg::*;
#(
   parameter int CH_W     = 6,
   parameter int ALPHA_W  = 8,
   parameter int X_W      = 10,
   parameter int Y_W      = 10,
   parameter int WW_W     = 6,
   parameter int UNIT_LG2 = 4,
   localparam int PIX_W   = NUM_CH * CH_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_en,
   input  logic               de_in,
   input  logic [X_W-1:0]     pos_x,
   input  logic [Y_W-1:0]     pos_y,
   input  logic [PIX_W-1:0]   bg_pix,
   input  logic [PIX_W-1:0]   fg_pix,
   input  logic               win_en,
   input  logic [ALPHA_W-1:0] alpha,
   input  logic               key_en,
   input  logic [CH_W-1:0]    key_r,
   input  logic [CH_W-1:0]    key_g,
   input  logic [CH_W-1:0]    key_b,
   input  logic [X_W-1:0]     win_x,
   input  logic [Y_W-1:0]     win_y,
   input  logic [WW_W-1:0]    win_w16,
   input  logic [Y_W-1:0]     win_h,
   output logic [PIX_W-1:0]   out_pix,
   output logic               out_de
);
   initial begin : elab_chk
      assert (CH_W >= 1) else $error("CH_W must be at least 1");
      assert (ALPHA_W >= 1 && ALPHA_W <= 16) else $error("ALPHA_W out of range");
      assert (X_W >= 1 && Y_W >= 1) else $error("coordinate widths must be positive");
      assert (WW_W >= 1) else $error("WW_W must be at least 1");
      assert (UNIT_LG2 >= 0 && UNIT_LG2 <= 8) else $error("UNIT_LG2 out of range");
   end

   logic             in_win;
   logic             key_hit;
   logic [PIX_W-1:0] blend_pix;
   logic [PIX_W-1:0] nxt_pix;
   src_sel_e         src;

   pm_win_hit #(
      .X_W(X_W), .Y_W(Y_W), .WW_W(WW_W), .UNIT_LG2(UNIT_LG2)
   ) u_hit (
      .pos_x(pos_x), .pos_y(pos_y), .org_x(win_x), .org_y(win_y),
      .size_w(win_w16), .size_h(win_h), .hit(in_win)
   );

   pm_key_cmp #(.CH_W(CH_W)) u_key (
      .fg_pix(fg_pix), .key_r(key_r), .key_g(key_g), .key_b(key_b),
      .match(key_hit)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         pm_chan_blend #(.CH_W(CH_W), .ALPHA_W(ALPHA_W)) u_blend (
            .fg_ch (fg_pix[ch*CH_W +: CH_W]),
            .bg_ch (bg_pix[ch*CH_W +: CH_W]),
            .alpha (alpha),
            .mix_ch(blend_pix[ch*CH_W +: CH_W])
         );
      end
   endgenerate

   always_comb begin
      if (!win_en || !in_win)  src = SRC_BACK;
      else if (key_en)         src = key_hit ? SRC_BACK : SRC_FRONT;
      else                     src = SRC_MIX;
   end

   always_comb begin
      unique case (src)
         SRC_FRONT: nxt_pix = fg_pix;
         SRC_MIX:   nxt_pix = blend_pix;
         default:   nxt_pix = bg_pix;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pix <= '0;
         out_de  <= 1'b0;
      end else if (pix_en) begin
         out_pix <= nxt_pix;
         out_de  <= de_in;
      end
   end
endmodule

// File: rtl/plane_mixer_chk.sv
module plane_mixer_chk #(
   parameter int CH_W    = 6,
   parameter int ALPHA_W = 8,
   localparam int PIX_W  = 3 * CH_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_en,
   input logic               de_in,
   input logic [PIX_W-1:0]   bg_pix,
   input logic [PIX_W-1:0]   fg_pix,
   input logic               win_en,
   input logic [ALPHA_W-1:0] alpha,
   input logic               key_en,
   input logic [CH_W-1:0]    key_r,
   input logic [CH_W-1:0]    key_g,
   input logic [CH_W-1:0]    key_b,
   input logic [PIX_W-1:0]   out_pix,
   input logic               out_de
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(out_pix) && $stable(out_de));

   p_de_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> out_de == $past(de_in));

   p_off_bg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && !win_en |=> out_pix == $past(bg_pix));

   p_alpha_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && !key_en && alpha == '0 |=> out_pix == $past(bg_pix));

   p_alpha_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && !key_en && alpha == '1 |=>
         (out_pix == $past(bg_pix)) || (out_pix == $past(fg_pix)));

   p_key_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && key_en && fg_pix == {key_r, key_g, key_b} |=> out_pix == $past(bg_pix));

   p_key_opaque_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && key_en |=> (out_pix == $past(bg_pix)) || (out_pix == $past(fg_pix)));
endmodule

bind plane_mixer plane_mixer_chk #(.CH_W(CH_W), .ALPHA_W(ALPHA_W)) u_chk (.*);

// File: tb/plane_mixer_tb.sv
`timescale 1ns/1ps
module plane_mixer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0, de_in = 1'b0;
   logic [9:0]  pos_x = '0, pos_y = '0;
   logic [17:0] bg_pix = '0, fg_pix = '0;
   logic        win_en = 1'b0, key_en = 1'b0;
   logic [7:0]  alpha = '0;
   logic [5:0]  key_r = '0, key_g = '0, key_b = '0;
   logic [9:0]  win_x = '0, win_y = '0, win_h = '0;
   logic [5:0]  win_w16 = '0;
   logic [17:0] out_pix;
   logic        out_de;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [17:0] exp_pix = '0;
   logic        exp_de = 1'b0;

   always #5 clk = ~clk;

   plane_mixer u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .de_in(de_in),
      .pos_x(pos_x), .pos_y(pos_y), .bg_pix(bg_pix), .fg_pix(fg_pix),
      .win_en(win_en), .alpha(alpha), .key_en(key_en),
      .key_r(key_r), .key_g(key_g), .key_b(key_b),
      .win_x(win_x), .win_y(win_y), .win_w16(win_w16), .win_h(win_h),
      .out_pix(out_pix), .out_de(out_de)
   );

   function automatic logic [17:0] ref_mix();
      int x_end, y_end;
      logic [17:0] r;
      x_end = int'(win_x) + 16 * int'(win_w16);
      y_end = int'(win_y) + int'(win_h);
      if (!win_en || int'(pos_x) < int'(win_x) || int'(pos_x) >= x_end ||
          int'(pos_y) < int'(win_y) || int'(pos_y) >= y_end)
         return bg_pix;
      if (key_en)
         return (fg_pix == {key_r, key_g, key_b}) ? bg_pix : fg_pix;
      for (int c = 0; c < 3; c++) begin
         int f, b, a;
         f = int'(fg_pix[c*6 +: 6]);
         b = int'(bg_pix[c*6 +: 6]);
         a = int'(alpha);
         r[c*6 +: 6] = 6'((f*a + b*(255-a) + 127) / 255);
      end
      return r;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (out_pix !== exp_pix || out_de !== exp_de) begin
         failures++;
         $display("FAIL %s: out_pix=%h out_de=%b expected pix=%h de=%b",
                  tag, out_pix, out_de, exp_pix, exp_de);
      end
   endtask

   // inputs are already set at a falling edge; one rising edge, then compare
   task automatic cycle(input string tag);
      if (pix_en) begin
         exp_pix = ref_mix();
         exp_de  = de_in;
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic set_win(input logic en, input int x, input int y,
                          input int w16, input int h);
      win_en = en; win_x = 10'(x); win_y = 10'(y);
      win_w16 = 6'(w16); win_h = 10'(h);
   endtask

   task automatic at(input int x, input int y);
      pos_x = 10'(x); pos_y = 10'(y);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      exp_pix = '0; exp_de = 1'b0;
      check("R1 reset");
      rst_n = 1'b1;

      bg_pix = 18'h15555; fg_pix = 18'h2AAAA; de_in = 1'b1; pix_en = 1'b1;
      set_win(1'b1, 100, 50, 4, 20); alpha = 8'd255;
      at(110, 55); cycle("R1 opaque pixel packing");
      // R4 column edges: window spans columns 100..163, lines 50..69
      at(99, 55);  cycle("R4 left outside");
      at(100, 55); cycle("R4 left inside");
      at(163, 55); cycle("R4 right inside");
      at(164, 55); cycle("R4 right outside");
      at(120, 49); cycle("R4 top outside");
      at(120, 50); cycle("R4 top inside");
      at(120, 69); cycle("R4 bottom inside");
      at(120, 70); cycle("R4 bottom outside");

      // R2 hold while enable low, inputs changing
      at(110, 55); cycle("R2 load");
      pix_en = 1'b0; bg_pix = 18'h00FFF; fg_pix = 18'h3F000; de_in = 1'b0;
      cycle("R2 hold a");
      at(0, 0); cycle("R2 hold b");
      pix_en = 1'b1; cycle("R3 de low carried");
      de_in = 1'b1; cycle("R3 de high carried");

      // R5 disabled window
      set_win(1'b0, 0, 0, 63, 1023); at(5, 5); cycle("R5 disabled");

      // R6 and R7 blend levels
      set_win(1'b1, 0, 0, 63, 1023);
      bg_pix = {6'd0, 6'd63, 6'd20}; fg_pix = {6'd63, 6'd0, 6'd41};
      alpha = 8'd128; cycle("R6 alpha 128");
      alpha = 8'd1;   cycle("R6 alpha 1");
      alpha = 8'd254; cycle("R6 alpha 254");
      alpha = 8'd0;   cycle("R7 alpha 0 gives bg");
      alpha = 8'd255; cycle("R7 alpha 255 gives fg");

      // R8 key mode
      key_en = 1'b1; key_r = 6'd63; key_g = 6'd0; key_b = 6'd41; alpha = 8'd100;
      cycle("R8 key match hole");
      fg_pix = {6'd63, 6'd1, 6'd41}; cycle("R8 non-key opaque");
      // R9 key color ignored when keying off
      key_en = 1'b0; fg_pix = {6'd63, 6'd0, 6'd41}; alpha = 8'd200;
      cycle("R9 key ignored");

      // R10 empty windows
      set_win(1'b1, 0, 0, 0, 1023); at(0, 0); cycle("R10 zero width");
      set_win(1'b1, 0, 0, 10, 0); cycle("R10 zero height");
      // R4 window touching coordinate limit
      set_win(1'b1, 1000, 0, 63, 10); at(1023, 3); cycle("R4 far right");

      // R6 random traffic against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         if (i % 150 == 0) begin
            set_win($urandom_range(1, 0), $urandom_range(600, 0), $urandom_range(400, 0),
                    $urandom_range(30, 0), $urandom_range(300, 0));
            key_en = ($urandom_range(2, 0) == 0);
            key_r = 6'($urandom); key_g = 6'($urandom); key_b = 6'($urandom);
            alpha = 8'($urandom);
         end
         pix_en = ($urandom_range(4, 0) != 0);
         de_in  = 1'($urandom);
         at($urandom_range(1023, 0), $urandom_range(700, 0));
         bg_pix = 18'($urandom);
         fg_pix = ($urandom_range(3, 0) == 0) ? {key_r, key_g, key_b} : 18'($urandom);
         cycle(key_en ? "R8 random" : "R6 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule